// File: doc/BRIEF.md
# Rectangle Copy Tile Splitter

This block takes one rectangle-copy request and turns it into a stream of work descriptors for a downstream copy engine. A request carries the source and destination origins, the rectangle width and height, the pixel size in bytes, whether each surface is stored row-linear or swizzled, the destination surface dimensions, both surface base addresses and both row pitches. The block classifies the request onto one of three copy paths, then walks the rectangle and emits one packed descriptor per accepted beat on a valid/ready output.

The row-linear path walks the rectangle in bands of rows, each band becoming one descriptor with precomputed source and destination byte addresses. The swizzle path walks it in tiles, rows of tiles outermost, each tile becoming one descriptor with its destination point, its size, an even-rounded size and its source byte address. When neither engine path applies, the block emits nothing and reports a per-pixel fallback, leaving that copy to software. Every request ends with a one-cycle done pulse that also reports the chosen path.

Top module: `rect_copy_splitter`

## Requirements
- R1: The request takes the row-linear path (code 1) when neither surface is swizzled, or when the destination surface width is 2 or less, or when its height is 1 or less.
- R2: Otherwise the request takes the swizzle path (code 2) when the source is linear, the destination is swizzled, the pixel size is not 1 and the destination base address has its low 6 bits all zero.
- R3: Every other request takes the fallback path (code 3): no descriptor is emitted, only the done pulse. Descriptor kind (bits 129:128) is always 1 or 2.
- R4: On the row-linear path the height is cut into bands of at most 2047 rows, top first; word3 (bits 31:0) carries the band's row count.
- R5: For a row-linear band starting at row r, word0 (bits 127:96) = src_base + (sy+r)*src_pitch + sx*bpp, word1 (bits 95:64) = dst_base + (dy+r)*dst_pitch + dx*bpp, and word2 (bits 63:32) = width*bpp.
- R6: On the swizzle path tiles are at most 1024 wide and 1024 tall, clipped to the rectangle edge; tile columns advance in the inner loop and tile rows in the outer loop.
- R7: A swizzle descriptor carries in word0 the destination point (dy+row in bits 31:16, dx+col in bits 15:0) and in word1 the tile size (height in 31:16, width in 15:0).
- R8: A swizzle descriptor carries in word2 the tile size with height and width each rounded up to an even number, packed like word1.
- R9: A swizzle descriptor carries in word3 the source byte address src_base + (sy+row)*src_pitch + (sx+col)*bpp.
- R10: While a descriptor is valid and not accepted, valid stays high and the descriptor does not change.
- R11: A request is accepted only while req_ready is high, which is only when no request is in progress; request inputs presented while busy have no effect.
- R12: A request with zero width or zero height emits no descriptor and gives only the done pulse, reporting the classified path.
- R13: done_o is high for exactly one cycle, the cycle after the last descriptor is accepted (or after acceptance when there are none), with done_path_o giving the path code.
- R14: After reset req_ready is high and desc_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken this cycle if valid |
| req_src_x_i | input | 16 | Source origin X |
| req_src_y_i | input | 16 | Source origin Y |
| req_dst_x_i | input | 16 | Destination origin X |
| req_dst_y_i | input | 16 | Destination origin Y |
| req_width_i | input | 16 | Rectangle width in pixels |
| req_height_i | input | 16 | Rectangle height in rows |
| req_bpp_i | input | BPP_W | Bytes per pixel |
| req_src_swz_i | input | 1 | Source surface is swizzled |
| req_dst_swz_i | input | 1 | Destination surface is swizzled |
| req_surf_w_i | input | 16 | Destination surface width |
| req_surf_h_i | input | 16 | Destination surface height |
| req_src_base_i | input | 32 | Source surface base address |
| req_dst_base_i | input | 32 | Destination surface base address |
| req_src_pitch_i | input | 16 | Source row pitch in bytes |
| req_dst_pitch_i | input | 16 | Destination row pitch in bytes |
| desc_valid_o | output | 1 | Descriptor present |
| desc_ready_i | input | 1 | Downstream takes descriptor |
| desc_o | output | 130 | Packed descriptor: kind, word0..word3 |
| done_o | output | 1 | One-cycle end-of-request pulse |
| done_path_o | output | 2 | Path code of the finished request |

## Verification
A corrupted walk position shows up on the very next descriptor as a wrong address, point or size word, because every field is computed from the position registers; a wrong classification shows at once in the descriptor kind or as descriptors where the fallback expects none. A band or tile advance that stops early or late shows as a descriptor count mismatch at the done pulse, which closes every request. Holding stability is exposed within one stalled beat, since the bench stalls the output at random.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        PATH_NONE     = 2'd0,
        PATH_LINEAR   = 2'd1,
        PATH_SWIZZLE  = 2'd2,
        PATH_FALLBACK = 2'd3
    } path_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LIN,
        ST_SWZ,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [1:0]        kind;
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
        logic [WORD_W-1:0] w2;
        logic [WORD_W-1:0] w3;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);
endpackage

// File: rtl/rcs_path_sel.sv
module rcs_path_sel
    import rcs_pkg::*;
#(
    parameter int BPP_W      = 3,
    parameter int ALIGN_LOG2 = 6
) (
    input  logic              src_swz_i,
    input  logic              dst_swz_i,
    input  logic [HALF_W-1:0] surf_w_i,
    input  logic [HALF_W-1:0] surf_h_i,
    input  logic [BPP_W-1:0]  bpp_i,
    input  logic [WORD_W-1:0] dst_base_i,
    output path_e             path_o
);
    localparam logic [HALF_W-1:0] NARROW_W = HALF_W'(2);
    localparam logic [HALF_W-1:0] SHORT_H  = HALF_W'(1);

    logic both_linear;
    logic tiny_dst;
    logic aligned;
    logic swz_ok;

    always_comb begin
        both_linear = !src_swz_i && !dst_swz_i;
        tiny_dst    = (surf_w_i <= NARROW_W) || (surf_h_i <= SHORT_H);
        aligned     = (dst_base_i[ALIGN_LOG2-1:0] == '0);
        swz_ok      = !src_swz_i && dst_swz_i && (bpp_i != BPP_W'(1)) && aligned;
        if (both_linear || tiny_dst) begin
            path_o = PATH_LINEAR;
        end else if (swz_ok) begin
            path_o = PATH_SWIZZLE;
        end else begin
            path_o = PATH_FALLBACK;
        end
    end
endmodule

// File: rtl/rcs_span_clip.sv
module rcs_span_clip
    import rcs_pkg::*;
(
    input  logic [HALF_W-1:0] limit_i,
    input  logic [HALF_W-1:0] total_i,
    input  logic [HALF_W-1:0] pos_i,
    output logic [HALF_W-1:0] len_o,
    output logic              last_o
);
    logic [HALF_W-1:0] remain;

    always_comb begin
        remain = total_i - pos_i;
        if (remain <= limit_i) begin
            len_o  = remain;
            last_o = 1'b1;
        end else begin
            len_o  = limit_i;
            last_o = 1'b0;
        end
    end
endmodule

// File: rtl/rcs_addr_calc.sv
module rcs_addr_calc
    import rcs_pkg::*;
#(
    parameter int BPP_W = 3
) (
    input  logic [WORD_W-1:0] base_i,
    input  logic [HALF_W-1:0] row_i,
    input  logic [HALF_W-1:0] pitch_i,
    input  logic [HALF_W-1:0] col_i,
    input  logic [BPP_W-1:0]  bpp_i,
    output logic [WORD_W-1:0] addr_o
);
    logic [WORD_W-1:0] row_bytes;
    logic [WORD_W-1:0] col_bytes;

    always_comb begin
        row_bytes = WORD_W'(row_i) * WORD_W'(pitch_i);
        col_bytes = WORD_W'(col_i) * WORD_W'(bpp_i);
        addr_o    = base_i + row_bytes + col_bytes;
    end
endmodule

// File: rtl/rect_copy_splitter.sv
module rect_copy_splitter
    import rcs_pkg::*;
#(
    parameter int MAX_ROWS   = 2047,
    parameter int TILE_W     = 1024,
    parameter int TILE_H     = 1024,
    parameter int ALIGN_LOG2 = 6,
    parameter int BPP_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [15:0]       req_src_x_i,
    input  logic [15:0]       req_src_y_i,
    input  logic [15:0]       req_dst_x_i,
    input  logic [15:0]       req_dst_y_i,
    input  logic [15:0]       req_width_i,
    input  logic [15:0]       req_height_i,
    input  logic [BPP_W-1:0]  req_bpp_i,
    input  logic              req_src_swz_i,
    input  logic              req_dst_swz_i,
    input  logic [15:0]       req_surf_w_i,
    input  logic [15:0]       req_surf_h_i,
    input  logic [31:0]       req_src_base_i,
    input  logic [31:0]       req_dst_base_i,
    input  logic [15:0]       req_src_pitch_i,
    input  logic [15:0]       req_dst_pitch_i,
    output logic              desc_valid_o,
    input  logic              desc_ready_i,
    output logic [129:0]      desc_o,
    output logic              done_o,
    output logic [1:0]        done_path_o
);
    localparam logic [HALF_W-1:0] ROW_LIMIT = HALF_W'(MAX_ROWS);
    localparam logic [HALF_W-1:0] TW_LIMIT  = HALF_W'(TILE_W);
    localparam logic [HALF_W-1:0] TH_LIMIT  = HALF_W'(TILE_H);

    typedef struct packed {
        logic [HALF_W-1:0] sx;
        logic [HALF_W-1:0] sy;
        logic [HALF_W-1:0] dx;
        logic [HALF_W-1:0] dy;
        logic [HALF_W-1:0] w;
        logic [HALF_W-1:0] h;
        logic [BPP_W-1:0]  bpp;
        logic [WORD_W-1:0] sbase;
        logic [WORD_W-1:0] dbase;
        logic [HALF_W-1:0] spitch;
        logic [HALF_W-1:0] dpitch;
    } job_t;

    typedef struct packed {
        state_e            st;
        path_e             path;
        job_t              job;
        logic [HALF_W-1:0] ypos;
        logic [HALF_W-1:0] xpos;
    } regs_t;

    regs_t  cur_q, nxt_d;
    path_e  sel_path;
    job_t   in_job;
    desc_t  desc_d;

    logic [HALF_W-1:0] h_limit;
    logic [HALF_W-1:0] h_len;
    logic              h_last;
    logic [HALF_W-1:0] w_len;
    logic              w_last;
    logic [WORD_W-1:0] src_addr;
    logic [WORD_W-1:0] dst_addr;
    logic [HALF_W-1:0] src_row;
    logic [HALF_W-1:0] src_col;
    logic [HALF_W-1:0] dst_row;
    logic [WORD_W-1:0] line_bytes;
    logic [HALF_W-1:0] even_w;
    logic [HALF_W-1:0] even_h;
    logic              beat;
    logic              empty_req;

    rcs_path_sel #(
        .BPP_W      (BPP_W),
        .ALIGN_LOG2 (ALIGN_LOG2)
    ) u_path_sel (
        .src_swz_i  (req_src_swz_i),
        .dst_swz_i  (req_dst_swz_i),
        .surf_w_i   (req_surf_w_i),
        .surf_h_i   (req_surf_h_i),
        .bpp_i      (req_bpp_i),
        .dst_base_i (req_dst_base_i),
        .path_o     (sel_path)
    );

    // Height walk: bands on the linear path, tile rows on the swizzle path.
    assign h_limit = (cur_q.st == ST_LIN) ? ROW_LIMIT : TH_LIMIT;

    rcs_span_clip u_clip_h (
        .limit_i (h_limit),
        .total_i (cur_q.job.h),
        .pos_i   (cur_q.ypos),
        .len_o   (h_len),
        .last_o  (h_last)
    );

    rcs_span_clip u_clip_w (
        .limit_i (TW_LIMIT),
        .total_i (cur_q.job.w),
        .pos_i   (cur_q.xpos),
        .len_o   (w_len),
        .last_o  (w_last)
    );

    assign src_row = cur_q.job.sy + cur_q.ypos;
    assign src_col = cur_q.job.sx + cur_q.xpos;
    assign dst_row = cur_q.job.dy + cur_q.ypos;

    rcs_addr_calc #(.BPP_W(BPP_W)) u_src_addr (
        .base_i  (cur_q.job.sbase),
        .row_i   (src_row),
        .pitch_i (cur_q.job.spitch),
        .col_i   (src_col),
        .bpp_i   (cur_q.job.bpp),
        .addr_o  (src_addr)
    );

    rcs_addr_calc #(.BPP_W(BPP_W)) u_dst_addr (
        .base_i  (cur_q.job.dbase),
        .row_i   (dst_row),
        .pitch_i (cur_q.job.dpitch),
        .col_i   (cur_q.job.dx),
        .bpp_i   (cur_q.job.bpp),
        .addr_o  (dst_addr)
    );

    always_comb begin
        in_job.sx     = req_src_x_i;
        in_job.sy     = req_src_y_i;
        in_job.dx     = req_dst_x_i;
        in_job.dy     = req_dst_y_i;
        in_job.w      = req_width_i;
        in_job.h      = req_height_i;
        in_job.bpp    = req_bpp_i;
        in_job.sbase  = req_src_base_i;
        in_job.dbase  = req_dst_base_i;
        in_job.spitch = req_src_pitch_i;
        in_job.dpitch = req_dst_pitch_i;
    end

    // Descriptor assembly from registered walk state only.
    always_comb begin
        line_bytes = WORD_W'(cur_q.job.w) * WORD_W'(cur_q.job.bpp);
        even_w     = w_len + HALF_W'(w_len[0]);
        even_h     = h_len + HALF_W'(h_len[0]);
        desc_d     = '0;
        case (cur_q.st)
            ST_LIN: begin
                desc_d.kind = PATH_LINEAR;
                desc_d.w0   = src_addr;
                desc_d.w1   = dst_addr;
                desc_d.w2   = line_bytes;
                desc_d.w3   = WORD_W'(h_len);
            end
            ST_SWZ: begin
                desc_d.kind = PATH_SWIZZLE;
                desc_d.w0   = {dst_row, cur_q.job.dx + cur_q.xpos};
                desc_d.w1   = {h_len, w_len};
                desc_d.w2   = {even_h, even_w};
                desc_d.w3   = src_addr;
            end
            default: desc_d = '0;
        endcase
    end

    always_comb begin
        nxt_d     = cur_q;
        beat      = desc_valid_o && desc_ready_i;
        empty_req = (req_width_i == '0) || (req_height_i == '0);
        case (cur_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    nxt_d.job  = in_job;
                    nxt_d.path = sel_path;
                    nxt_d.ypos = '0;
                    nxt_d.xpos = '0;
                    if (empty_req || sel_path == PATH_FALLBACK) begin
                        nxt_d.st = ST_DONE;
                    end else if (sel_path == PATH_LINEAR) begin
                        nxt_d.st = ST_LIN;
                    end else begin
                        nxt_d.st = ST_SWZ;
                    end
                end
            end
            ST_LIN: begin
                if (beat) begin
                    if (h_last) begin
                        nxt_d.st = ST_DONE;
                    end else begin
                        nxt_d.ypos = cur_q.ypos + h_len;
                    end
                end
            end
            ST_SWZ: begin
                if (beat) begin
                    if (w_last) begin
                        nxt_d.xpos = '0;
                        if (h_last) begin
                            nxt_d.st = ST_DONE;
                        end else begin
                            nxt_d.ypos = cur_q.ypos + h_len;
                        end
                    end else begin
                        nxt_d.xpos = cur_q.xpos + w_len;
                    end
                end
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.st   <= ST_IDLE;
            cur_q.path <= PATH_NONE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready_o  = (cur_q.st == ST_IDLE);
    assign desc_valid_o = (cur_q.st == ST_LIN) || (cur_q.st == ST_SWZ);
    assign desc_o       = desc_d;
    assign done_o       = (cur_q.st == ST_DONE);
    assign done_path_o  = cur_q.path;
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
    parameter int MAX_ROWS = 2047,
    parameter int TILE_W   = 1024,
    parameter int TILE_H   = 1024
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_ready_o,
    input logic         desc_valid_o,
    input logic         desc_ready_i,
    input logic [129:0] desc_o,
    input logic         done_o
);
    logic [1:0]  kind;
    logic [15:0] tile_h;
    logic [15:0] tile_w;
    logic [31:0] band_rows;
    logic [31:0] even_sz;

    assign kind      = desc_o[129:128];
    assign tile_h    = desc_o[95:80];
    assign tile_w    = desc_o[79:64];
    assign even_sz   = desc_o[63:32];
    assign band_rows = desc_o[31:0];

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_o));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !desc_valid_o && !done_o);

    // R3
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o |-> (kind == 2'd1 || kind == 2'd2));

    // R4
    band_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && kind == 2'd1 |-> band_rows != 32'd0 && band_rows <= 32'(MAX_ROWS));

    // R6
    tile_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && kind == 2'd2 |-> tile_w != 16'd0 && tile_w <= 16'(TILE_W)
                                         && tile_h != 16'd0 && tile_h <= 16'(TILE_H));

    // R8
    even_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid_o && kind == 2'd2 |-> !even_sz[0] && !even_sz[16]);
endmodule

bind rect_copy_splitter rcs_checker #(
    .MAX_ROWS (MAX_ROWS),
    .TILE_W   (TILE_W),
    .TILE_H   (TILE_H)
) u_rcs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready_o  (req_ready_o),
    .desc_valid_o (desc_valid_o),
    .desc_ready_i (desc_ready_i),
    .desc_o       (desc_o),
    .done_o       (done_o)
);

// File: tb/rect_copy_splitter_bench.sv
module rect_copy_splitter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         req_valid_i = 1'b0;
    logic         req_ready_o;
    logic [15:0]  sx_i = '0, sy_i = '0, dx_i = '0, dy_i = '0, w_i = '0, h_i = '0;
    logic [2:0]   bpp_i = 3'd1;
    logic         sswz_i = 1'b0, dswz_i = 1'b0;
    logic [15:0]  sw_i = '0, sh_i = '0, sp_i = '0, dp_i = '0;
    logic [31:0]  sb_i = '0, db_i = '0;
    logic         desc_valid_o;
    logic         desc_ready_i = 1'b0;
    logic [129:0] desc_o;
    logic         done_o;
    logic [1:0]   done_path_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [129:0] exp_q[$];

    rect_copy_splitter u_rect_copy_splitter (
        .clk (clk), .rst_n (rst_n),
        .req_valid_i (req_valid_i), .req_ready_o (req_ready_o),
        .req_src_x_i (sx_i), .req_src_y_i (sy_i),
        .req_dst_x_i (dx_i), .req_dst_y_i (dy_i),
        .req_width_i (w_i), .req_height_i (h_i),
        .req_bpp_i (bpp_i),
        .req_src_swz_i (sswz_i), .req_dst_swz_i (dswz_i),
        .req_surf_w_i (sw_i), .req_surf_h_i (sh_i),
        .req_src_base_i (sb_i), .req_dst_base_i (db_i),
        .req_src_pitch_i (sp_i), .req_dst_pitch_i (dp_i),
        .desc_valid_o (desc_valid_o), .desc_ready_i (desc_ready_i),
        .desc_o (desc_o), .done_o (done_o), .done_path_o (done_path_o)
    );

    task automatic check(input bit ok, input string req, input logic [129:0] act,
                         input logic [129:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_path(input logic ss, input logic ds,
            input logic [15:0] sw, input logic [15:0] sh, input logic [2:0] b,
            input logic [31:0] db);
        if ((!ss && !ds) || sw <= 16'd2 || sh <= 16'd1) return 2'd1;  // R1
        if (!ss && ds && b != 3'd1 && db[5:0] == 6'd0) return 2'd2;   // R2
        return 2'd3;                                                 // R3
    endfunction

    function automatic logic [15:0] even16(input logic [15:0] v);
        return v + {15'd0, v[0]};
    endfunction

    // Build the expected descriptor list for the request on the pins.
    task automatic build_expected(output logic [1:0] p);
        logic [31:0] lb;
        exp_q.delete();
        p = ref_path(sswz_i, dswz_i, sw_i, sh_i, bpp_i, db_i);
        if (w_i == 0 || h_i == 0 || p == 2'd3) return;
        lb = 32'(w_i) * 32'(bpp_i);
        if (p == 2'd1) begin
            for (int r = 0; r < int'(h_i); ) begin
                int cnt = (int'(h_i) - r > 2047) ? 2047 : int'(h_i) - r;
                logic [31:0] sa = sb_i + 32'(int'(sy_i) + r) * 32'(sp_i) + 32'(sx_i) * 32'(bpp_i);
                logic [31:0] da = db_i + 32'(int'(dy_i) + r) * 32'(dp_i) + 32'(dx_i) * 32'(bpp_i);
                exp_q.push_back({2'd1, sa, da, lb, 32'(cnt)});
                r += cnt;
            end
        end else begin
            for (int ty = 0; ty < int'(h_i); ) begin
                int th = (int'(h_i) - ty > 1024) ? 1024 : int'(h_i) - ty;
                for (int tx = 0; tx < int'(w_i); ) begin
                    int tw = (int'(w_i) - tx > 1024) ? 1024 : int'(w_i) - tx;
                    logic [31:0] pt = {16'(int'(dy_i) + ty), 16'(int'(dx_i) + tx)};
                    logic [31:0] sz = {16'(th), 16'(tw)};
                    logic [31:0] ev = {even16(16'(th)), even16(16'(tw))};
                    logic [31:0] sa = sb_i + 32'(int'(sy_i) + ty) * 32'(sp_i)
                                     + 32'(int'(sx_i) + tx) * 32'(bpp_i);
                    exp_q.push_back({2'd2, pt, sz, ev, sa});
                    tx += tw;
                end
                ty += th;
            end
        end
    endtask

    task automatic run_req(input bit junk_while_busy, input string tag);
        logic [1:0] p;
        int got;
        bit held;
        logic [129:0] held_val;
        build_expected(p);
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_valid_i = 1'b1;
        @(negedge clk);
        if (junk_while_busy) begin
            // R11: these values must not reach any descriptor
            sx_i = 16'h0123; sy_i = 16'h0456; w_i = 16'd3; h_i = 16'd3;
            sb_i = 32'hDEAD_0000; dswz_i = ~dswz_i;
        end else begin
            req_valid_i = 1'b0;
        end
        got = 0;
        held = 1'b0;
        held_val = '0;
        forever begin
            if (done_o) begin
                // R13 / R12 / R3: descriptor count and reported path
                check(got == exp_q.size(), {tag, " R13 count"}, 130'(got), 130'(exp_q.size()));
                check(done_path_o == p, {tag, " R13 path"}, 130'(done_path_o), 130'(p));
                check(!desc_valid_o, {tag, " R13 no valid at done"}, 130'(desc_valid_o), 130'd0);
                req_valid_i = 1'b0;
                break;
            end
            if (held) begin
                // R10
                check(desc_valid_o && desc_o == held_val, {tag, " R10 hold"}, desc_o, held_val);
            end
            desc_ready_i = ($urandom_range(0, 3) != 0);
            if (desc_valid_o && desc_ready_i) begin
                logic [129:0] e = (got < exp_q.size()) ? exp_q[got] : '1;
                // R4 R5 R6 R7 R8 R9
                check(desc_o == e, {tag, " R4-descriptor R5 R7 R8 R9"}, desc_o, e);
                got++;
            end
            held = desc_valid_o && !desc_ready_i;
            held_val = desc_o;
            @(negedge clk);
        end
        @(negedge clk);
        // R11: idle again after done
        check(req_ready_o && !done_o, {tag, " R11 ready after done"}, 130'(req_ready_o), 130'd1);
    endtask

    task automatic set_req(input logic [15:0] sx, sy, dx, dy, w, h, input logic [2:0] b,
                           input logic ss, ds, input logic [15:0] sw, sh,
                           input logic [31:0] sb, db, input logic [15:0] sp, dp);
        sx_i = sx; sy_i = sy; dx_i = dx; dy_i = dy; w_i = w; h_i = h; bpp_i = b;
        sswz_i = ss; dswz_i = ds; sw_i = sw; sh_i = sh; sb_i = sb; db_i = db;
        sp_i = sp; dp_i = dp;
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk) cycles++;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R14
        check(req_ready_o && !desc_valid_o && !done_o, "R14 reset state",
              {127'd0, req_ready_o, desc_valid_o, done_o}, 130'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 both linear, R4 tall band split: 2047, 2047, 906
        set_req(16'd3, 16'd5, 16'd7, 16'd2, 16'd10, 16'd5000, 3'd4, 1'b0, 1'b0,
                16'd64, 16'd64, 32'h1000, 32'h8000_0000, 16'd64, 16'd128);
        run_req(1'b0, "R1 R4 tall linear");
        // R1 tiny destination width forces linear despite swizzle
        set_req(16'd0, 16'd0, 16'd1, 16'd1, 16'd2, 16'd3, 3'd2, 1'b1, 1'b1,
                16'd2, 16'd64, 32'h200, 32'h300, 16'd8, 16'd8);
        run_req(1'b0, "R1 narrow dst");
        // R1 height-1 destination
        set_req(16'd0, 16'd0, 16'd0, 16'd0, 16'd4, 16'd1, 3'd1, 1'b0, 1'b1,
                16'd64, 16'd1, 32'h0, 32'h5, 16'd8, 16'd8);
        run_req(1'b0, "R1 flat dst");
        // R2 R6 multi-tile swizzle: 3 columns x 2 rows, odd edges
        set_req(16'd1, 16'd2, 16'd3, 16'd4, 16'd2501, 16'd1101, 3'd2, 1'b0, 1'b1,
                16'd4096, 16'd2048, 32'h40, 32'h4000, 16'd6000, 16'd8192);
        run_req(1'b0, "R2 R6 tiled swizzle");
        // R3 fallback: 1-byte pixels
        set_req(16'd0, 16'd0, 16'd0, 16'd0, 16'd8, 16'd8, 3'd1, 1'b0, 1'b1,
                16'd64, 16'd64, 32'h0, 32'h0, 16'd8, 16'd8);
        run_req(1'b0, "R3 byte pixels");
        // R3 fallback: misaligned destination
        set_req(16'd0, 16'd0, 16'd0, 16'd0, 16'd8, 16'd8, 3'd4, 1'b0, 1'b1,
                16'd64, 16'd64, 32'h0, 32'h20, 16'd32, 16'd32);
        run_req(1'b0, "R3 misaligned");
        // R3 fallback: swizzled source
        set_req(16'd0, 16'd0, 16'd0, 16'd0, 16'd8, 16'd8, 3'd4, 1'b1, 1'b0,
                16'd64, 16'd64, 32'h0, 32'h0, 16'd32, 16'd32);
        run_req(1'b0, "R3 swizzled source");
        // R12 zero width and zero height
        set_req(16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd9, 3'd4, 1'b0, 1'b0,
                16'd64, 16'd64, 32'h0, 32'h0, 16'd32, 16'd32);
        run_req(1'b0, "R12 zero width");
        set_req(16'd0, 16'd0, 16'd0, 16'd0, 16'd9, 16'd0, 3'd4, 1'b0, 1'b1,
                16'd64, 16'd64, 32'h0, 32'h0, 16'd32, 16'd32);
        run_req(1'b0, "R12 zero height");
        // R11 inputs changed while busy are ignored
        set_req(16'd2, 16'd2, 16'd0, 16'd0, 16'd5, 16'd4100, 3'd2, 1'b0, 1'b0,
                16'd64, 16'd64, 32'h100, 32'h200, 16'd16, 16'd16);
        run_req(1'b1, "R11 busy junk");

        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic [15:0] sws[5] = '{16'd1, 16'd2, 16'd4, 16'd64, 16'd256};
            logic [2:0]  bs[3]  = '{3'd1, 3'd2, 3'd4};
            set_req(16'($urandom_range(0, 50)), 16'($urandom_range(0, 50)),
                    16'($urandom_range(0, 50)), 16'($urandom_range(0, 50)),
                    16'($urandom_range(0, 40)), 16'($urandom_range(0, 40)),
                    bs[$urandom_range(0, 2)], 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    sws[$urandom_range(0, 4)], sws[$urandom_range(0, 4)],
                    32'($urandom_range(0, 65535)),
                    ($urandom_range(0, 1) != 0) ? 32'($urandom_range(0, 1023)) << 6
                                                : 32'($urandom_range(0, 65535)),
                    16'($urandom_range(200, 400)), 16'($urandom_range(200, 400)));
            run_req(1'b0, "R1 R2 R3 R5 R9 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule